// File: doc/BRIEF.md
# Refresh Injection Rank Tracker

This block brings one refresh or ZQ calibration request for a single rank into a DRAM controller's request flow without disturbing work already in flight. The request arrives on its own one-deep channel, apart from the normal request path. On the cycle it is taken, every occupied bank machine is compared against the refresh rank. The matching machines are recorded in a pending vector. As each of those machines reports completion, its bit is removed. When the vector is empty, the block asks the row arbiter to force the refresh through and holds that request until the arbiter acknowledges it.

While a refresh is outstanding, the block raises a per-rank hold that stops new activates to that rank. At injection it also sets a sticky "queue holds a read" flag on each matching machine, so a starved write cannot hold the refresh off forever. It gives a one-cycle auto-precharge mark to matching machines that are the tail of their bank queue and whose timing allows it. A matching machine without that mark is expected to close its bank with an explicit precharge.

Top module: `refresh_inject`

## Requirements
- R1: After reset, `ref_ready` is 1, `force_ref` is 0, and `pend_mask`, `q_has_rd`, `auto_pre` and `act_hold` are all 0.
- R2: A request is taken in a cycle where `ref_req` and `ref_ready` are both 1. The machine rank fields are packed with machine i in bits [i*RANK_W +: RANK_W] of `mach_rank`. From the next cycle, `pend_mask` bit i is 1 exactly when machine i was busy, its rank equalled `ref_rank`, and its `mach_end` bit was low in the taking cycle.
- R3: An end pulse on `mach_end[i]` clears `pend_mask[i]` on the next edge. `force_ref` rises on the same edge that clears the last pending bit.
- R4: If no machine matches when a request is taken, `force_ref` is 1 from the edge that takes it.
- R5: End pulses from machines whose bit is not set in `pend_mask` leave `pend_mask` unchanged.
- R6: `ref_ready` is 0 from the edge that takes a request until the edge after `ref_ack`. A `ref_req` made while `ref_ready` is 0 is ignored, so the held rank does not change.
- R7: While a request is held, `act_hold` has exactly the bit of the held rank set. Otherwise it is all zero.
- R8: The edge that takes a request sets `q_has_rd[i]` for every machine captured in `pend_mask`. The flag stays set until that machine's `mach_end` pulse.
- R9: For one cycle after the taking edge, `auto_pre[i]` is 1 for each captured machine that had both `mach_tail[i]` and `pre_ok[i]` set.
- R10: `force_ref` stays 1 until `ref_ack`. It is 0 after the edge on which `ref_ack` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_req | input | 1 | Refresh or ZQ request on the private channel |
| ref_rank | input | RANK_W | Rank of the request |
| ref_ready | output | 1 | Channel can take a request |
| ref_ack | input | 1 | Row arbiter has issued the forced refresh |
| mach_busy | input | N_MACH | Bank machine holds a request |
| mach_rank | input | N_MACH*RANK_W | Packed rank of each machine |
| mach_tail | input | N_MACH | Machine is tail of its bank queue |
| pre_ok | input | N_MACH | Timing allows auto-precharge for the machine |
| mach_end | input | N_MACH | One-hot completion pulse per machine |
| pend_mask | output | N_MACH | Machines still to finish before the refresh |
| force_ref | output | 1 | Force the refresh through the row arbiter |
| act_hold | output | 2**RANK_W | Activates blocked, one bit per rank |
| q_has_rd | output | N_MACH | Sticky read-priority flag per machine |
| auto_pre | output | N_MACH | One-cycle auto-precharge mark per machine |

## Verification
The hardest case to reach is a machine that completes in the same cycle the request is taken. That machine matches on rank but must not appear in the captured vector. The stimulus reaches this case by holding a busy, matching machine and raising its end pulse together with `ref_req`. It also drives stray end pulses and repeated requests while the tracker is draining, which shows that neither the vector nor the held rank can be disturbed.

// File: rtl/refi_pkg.sv
package refi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_FORCE = 2'd2
    } refi_st_e;
endpackage

// File: rtl/refi_match.sv
module refi_match #(
    parameter int N_MACH = 4,
    parameter int RANK_W = 2
) (
    input  logic [N_MACH-1:0]        mach_busy,
    input  logic [N_MACH*RANK_W-1:0] mach_rank,
    input  logic [N_MACH-1:0]        mach_end,
    input  logic [RANK_W-1:0]        ref_rank,
    output logic [N_MACH-1:0]        hit
);
    for (genvar g = 0; g < N_MACH; g++) begin : g_cmp
        // a machine finishing this cycle no longer needs to be waited on
        assign hit[g] = mach_busy[g] && !mach_end[g] &&
                        (mach_rank[g*RANK_W +: RANK_W] == ref_rank);
    end
endmodule

// File: rtl/refi_flags.sv
module refi_flags #(
    parameter int N_MACH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inject,
    input  logic [N_MACH-1:0] hit,
    input  logic [N_MACH-1:0] mach_tail,
    input  logic [N_MACH-1:0] pre_ok,
    input  logic [N_MACH-1:0] mach_end,
    output logic [N_MACH-1:0] q_has_rd,
    output logic [N_MACH-1:0] auto_pre
);
    typedef struct packed {
        logic [N_MACH-1:0] rd;
        logic [N_MACH-1:0] ap;
    } flags_t;

    flags_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.ap = '0;
        s_d.rd = s_q.rd & ~mach_end;
        if (inject) begin
            s_d.rd = s_d.rd | hit;
            s_d.ap = hit & mach_tail & pre_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q_has_rd = s_q.rd;
    assign auto_pre = s_q.ap;

    for (genvar g = 0; g < N_MACH; g++) begin : g_chk
        // R8: flag only drops on the owner's completion
        p_rd_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (q_has_rd[g] && !mach_end[g]) |=> q_has_rd[g]);
        // R9: auto-precharge is a single-cycle mark
        p_ap_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
            auto_pre[g] |=> !auto_pre[g]);
    end
endmodule

// File: rtl/refresh_inject.sv
module refresh_inject
    import refi_pkg::*;
#(
    parameter int N_MACH = 4,
    parameter int RANK_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ref_req,
    input  logic [RANK_W-1:0]        ref_rank,
    output logic                     ref_ready,
    input  logic                     ref_ack,
    input  logic [N_MACH-1:0]        mach_busy,
    input  logic [N_MACH*RANK_W-1:0] mach_rank,
    input  logic [N_MACH-1:0]        mach_tail,
    input  logic [N_MACH-1:0]        pre_ok,
    input  logic [N_MACH-1:0]        mach_end,
    output logic [N_MACH-1:0]        pend_mask,
    output logic                     force_ref,
    output logic [(1<<RANK_W)-1:0]   act_hold,
    output logic [N_MACH-1:0]        q_has_rd,
    output logic [N_MACH-1:0]        auto_pre
);
    localparam int N_RANK = 1 << RANK_W;

    typedef struct packed {
        refi_st_e          st;
        logic [RANK_W-1:0] rank;
        logic [N_MACH-1:0] pend;
    } trk_t;

    trk_t s_d, s_q;
    logic [N_MACH-1:0] hit;
    logic              inject;

    refi_match #(.N_MACH(N_MACH), .RANK_W(RANK_W)) u_match (
        .mach_busy (mach_busy),
        .mach_rank (mach_rank),
        .mach_end  (mach_end),
        .ref_rank  (ref_rank),
        .hit       (hit)
    );

    assign inject = ref_req && (s_q.st == ST_IDLE);

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: if (ref_req) begin
                s_d.rank = ref_rank;
                s_d.pend = hit;
                s_d.st   = (hit == '0) ? ST_FORCE : ST_DRAIN;
            end
            ST_DRAIN: begin
                s_d.pend = s_q.pend & ~mach_end;
                if (s_d.pend == '0) s_d.st = ST_FORCE;
            end
            ST_FORCE: if (ref_ack) s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, rank: '0, pend: '0};
        else        s_q <= s_d;
    end

    refi_flags #(.N_MACH(N_MACH)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .inject    (inject),
        .hit       (hit),
        .mach_tail (mach_tail),
        .pre_ok    (pre_ok),
        .mach_end  (mach_end),
        .q_has_rd  (q_has_rd),
        .auto_pre  (auto_pre)
    );

    assign ref_ready = (s_q.st == ST_IDLE);
    assign force_ref = (s_q.st == ST_FORCE);
    assign pend_mask = s_q.pend;

    for (genvar r = 0; r < N_RANK; r++) begin : g_hold
        assign act_hold[r] = (s_q.st != ST_IDLE) && (s_q.rank == r);
    end

    // R3: force only once the captured machines are all done
    p_force_drained_r3: assert property (@(posedge clk) disable iff (!rst_n)
        force_ref |-> (pend_mask == '0));
    // R5: while draining the vector only loses bits
    p_pend_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_ready |=> ((pend_mask & ~$past(pend_mask)) == '0));
    // R6: held rank is stable while a request is outstanding
    p_rank_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_ready && !ref_ack) |=> $stable(act_hold));
    // R7: at most one rank is blocked
    p_hold_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_hold) && (ref_ready == (act_hold == '0)));
    // R10: force persists without acknowledge
    p_force_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (force_ref && !ref_ack) |=> force_ref);
endmodule

// File: tb/refresh_inject_test.sv
module refresh_inject_test;
    localparam int N  = 4;
    localparam int RW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_req = 1'b0, ref_ack = 1'b0;
    logic [RW-1:0] ref_rank = '0;
    logic [N-1:0] mach_busy = '0, mach_tail = '0, pre_ok = '0, mach_end = '0;
    logic [N*RW-1:0] mach_rank = '0;
    logic ref_ready, force_ref;
    logic [N-1:0] pend_mask, q_has_rd, auto_pre;
    logic [(1<<RW)-1:0] act_hold;

    int total = 0;
    int bad = 0;

    always #4ns clk = ~clk;

    refresh_inject #(.N_MACH(N), .RANK_W(RW)) uut (
        .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_rank(ref_rank),
        .ref_ready(ref_ready), .ref_ack(ref_ack), .mach_busy(mach_busy),
        .mach_rank(mach_rank), .mach_tail(mach_tail), .pre_ok(pre_ok),
        .mach_end(mach_end), .pend_mask(pend_mask), .force_ref(force_ref),
        .act_hold(act_hold), .q_has_rd(q_has_rd), .auto_pre(auto_pre)
    );

    // busy, ranks, tail, pre_ok, ref rank, expected pending, expected auto-precharge
    localparam logic [29:0] VEC [4] = '{
        {4'b1111, 8'b10000100, 4'b0101, 4'b1111, 2'd0, 4'b0101, 4'b0101},
        {4'b1011, 8'hFF,       4'b1111, 4'b0011, 2'd3, 4'b1011, 4'b0011},
        {4'b1111, 8'h00,       4'b1111, 4'b1111, 2'd1, 4'b0000, 4'b0000},
        {4'b0100, 8'h69,       4'b0100, 4'b0000, 2'd2, 4'b0100, 4'b0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic take(input logic [RW-1:0] rk);
        ref_req  = 1'b1;
        ref_rank = rk;
        tick();
        ref_req  = 1'b0;
    endtask

    task automatic ack_it();
        ref_ack = 1'b1;
        tick();
        ref_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 ready", ref_ready, 1);
        chk("R1 force", force_ref, 0);
        chk("R1 pend", pend_mask, 0);
        chk("R1 qrd", q_has_rd, 0);
        chk("R1 ap", auto_pre, 0);
        chk("R1 hold", act_hold, 0);

        for (int v = 0; v < 4; v++) begin
            logic [N-1:0] ep;
            ep        = VEC[v][7:4];
            mach_busy = VEC[v][29:26];
            mach_rank = VEC[v][25:18];
            mach_tail = VEC[v][17:14];
            pre_ok    = VEC[v][13:10];
            take(VEC[v][9:8]);
            chk("R2 pend", pend_mask, ep);
            chk("R9 ap", auto_pre, VEC[v][3:0]);
            chk("R8 qrd", q_has_rd, ep);
            chk("R6 ready low", ref_ready, 0);
            chk("R7 hold", act_hold, 1 << VEC[v][9:8]);
            chk("R4 force", force_ref, ep == 0);
            tick();
            chk("R9 ap gone", auto_pre, 0);
            for (int i = 0; i < N; i++) begin
                if (ep[i]) begin
                    chk("R3 no early force", force_ref, 0);
                    mach_end = 4'b0001 << i;
                    tick();
                    mach_end = '0;
                    ep[i] = 1'b0;
                    chk("R3 pend drain", pend_mask, ep);
                    chk("R8 qrd clear", q_has_rd, ep);
                end
            end
            chk("R3 force", force_ref, 1);
            ack_it();
            chk("R10 force off", force_ref, 0);
            chk("R6 ready back", ref_ready, 1);
            chk("R7 hold off", act_hold, 0);
        end

        // R2: machine ending in the taking cycle is excluded
        mach_busy = 4'b0011;
        mach_rank = 8'h00;
        mach_tail = '0;
        pre_ok    = '0;
        mach_end  = 4'b0001;
        take(2'd0);
        mach_end = '0;
        chk("R2 end excluded", pend_mask, 4'b0010);

        // R5: stray end pulses do not touch the vector
        mach_end = 4'b1100;
        tick();
        mach_end = '0;
        chk("R5 stray end", pend_mask, 4'b0010);

        // R6: second request ignored while busy
        take(2'd3);
        chk("R6 ignored req", act_hold, 4'b0001);
        chk("R6 ignored pend", pend_mask, 4'b0010);

        // R8: flag held across idle cycles
        repeat (3) tick();
        chk("R8 sticky", q_has_rd, 4'b0010);

        mach_end = 4'b0010;
        tick();
        mach_end = '0;
        chk("R3 force after last", force_ref, 1);

        // R10: force persists with no acknowledge
        repeat (4) tick();
        chk("R10 force held", force_ref, 1);
        chk("R6 still busy", ref_ready, 0);
        ack_it();
        chk("R10 released", force_ref, 0);
        chk("R6 ready again", ref_ready, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule